// File: doc/BRIEF.md
# Multi-line summation and binning unit

This unit takes four time-aligned line-scan pixel streams, called lines A to D, and merges them into one output line. The merge follows a sensor mode chosen per line. It can pass a single line through, add two lines, or add four lines. Two binned modes also add each pair of horizontally adjacent pixels, so the output line is half as wide. An optional one-half gain can be applied after the sum, and every result is clamped at the full-scale value of the pixel depth.

Every line is first written into one half of a two-bank line memory. It is read back from there as soon as its last pixel has arrived, either in arrival order or mirrored, while the next line fills the other bank. The output therefore trails the input by one line. It leaves the unit as one unbroken burst per line, which is as fast as lines can arrive.

The configuration is sampled on the pixel that carries the start-of-line flag and holds for the whole line. Input lines are assumed to contain exactly LINE_W valid pixels, the first one flagged as start of line. Idle cycles may occur inside a line and between lines. LINE_W must be an even power of two.

Top module: `linesum_bin`

## Requirements
- R1: With cfg_mode 0 (single), each output pixel equals line B. Codes 5 to 7 behave exactly like code 0, including the gain rule of R6.
- R2: With cfg_mode 1 (pair), each output pixel is B+C, clamped as in R7.
- R3: With cfg_mode 2 (quad), each output pixel is (A+B)+(C+D), clamped as in R7.
- R4: With cfg_mode 3 (single binned), output pixel k is the sum of (A+B) at input positions 2k and 2k+1, and the line carries LINE_W/2 pixels.
- R5: With cfg_mode 4 (quad binned), output pixel k is the sum of (A+B)+(C+D) at input positions 2k and 2k+1, and the line carries LINE_W/2 pixels.
- R6: When cfg_half is 1, the full sum is shifted right by one bit (floor of half) before clamping, in modes 1 to 4. In modes 0 and 5 to 7, cfg_half has no effect.
- R7: Any result above 2^PIX_W-1 is output as 2^PIX_W-1. Sums never wrap.
- R8: When cfg_rev is 1 for a line, that line's output pixels come out in reverse horizontal order. When cfg_rev is 0, they come out in arrival order.
- R9: Each line is emitted after its last input pixel as one burst of consecutive out_valid cycles. out_sol is high on the first pixel of the burst only. Every input line produces exactly one output line, in input order.
- R10: cfg_mode, cfg_half and cfg_rev are sampled only on the valid pixel with in_sol high. Changes at any other time do not affect that line.
- R11: While rst is high and in the cycle after it is released, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One pixel of each of the four lines is present |
| in_sol | input | 1 | Present pixel is the first of a line |
| line_a | input | PIX_W | Pixel of line A |
| line_b | input | PIX_W | Pixel of line B |
| line_c | input | PIX_W | Pixel of line C |
| line_d | input | PIX_W | Pixel of line D |
| cfg_mode | input | 3 | Sensor mode code, sampled at start of line |
| cfg_half | input | 1 | One-half gain select, sampled at start of line |
| cfg_rev | input | 1 | Mirror the line, sampled at start of line |
| out_valid | output | 1 | Output pixel valid |
| out_sol | output | 1 | Output pixel is the first of a line |
| out_pix | output | PIX_W | Output pixel |

## Verification
Two things can happen in the same cycle. The configuration capture for a new line can coincide with the read-out of the previous line from the other bank. Also, the write of a line's last pixel can land in the very cycle that the previous burst ends. Both are provoked by sending lines back to back with no idle cycle, while the mode, gain and mirror settings differ from line to line. Binned and full-width lines are mixed so that burst lengths change. On some lines the configuration inputs are also scrambled after the start-of-line pixel. Each output pixel is judged against a queue of values computed arithmetically from the four inputs. The start-of-line flag and the absence of gaps inside a burst are checked as well, so any mixing of settings between neighbouring lines shows up as a wrong value or a broken burst.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

  localparam logic [2:0] MODE_SINGLE = 3'd0;
  localparam logic [2:0] MODE_PAIR   = 3'd1;
  localparam logic [2:0] MODE_QUAD   = 3'd2;
  localparam logic [2:0] MODE_SBIN   = 3'd3;
  localparam logic [2:0] MODE_QBIN   = 3'd4;

  typedef struct packed {
    logic [2:0] mode;
    logic       half;
    logic       rev;
  } line_cfg_t;

  function automatic logic mode_binned(input logic [2:0] m);
    return (m == MODE_SBIN) || (m == MODE_QBIN);
  endfunction

  function automatic logic mode_single(input logic [2:0] m);
    return !((m == MODE_PAIR) || (m == MODE_QUAD) || (m == MODE_SBIN) || (m == MODE_QBIN));
  endfunction

endpackage

// File: rtl/lsb_vsum.sv
module lsb_vsum
  import lsb_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 1024
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_sol,
  input  logic [PIX_W-1:0]       a,
  input  logic [PIX_W-1:0]       b,
  input  logic [PIX_W-1:0]       c,
  input  logic [PIX_W-1:0]       d,
  input  line_cfg_t              cfg_in,
  output logic                   out_valid,
  output logic                   out_sol,
  output logic                   out_eol,
  output logic [PIX_W+2:0]       out_sum,
  output line_cfg_t              out_cfg
);

  localparam int SUM_W = PIX_W + 3;
  localparam int IDX_W = $clog2(LINE_W);

  logic [IDX_W-1:0] idx_q, idx_cur;
  line_cfg_t        cfg_q, cfg_cur;
  logic [SUM_W-1:0] pair_ab, pair_cd, vsum;

  always_comb begin
    cfg_cur = in_sol ? cfg_in : cfg_q;
    idx_cur = in_sol ? '0 : idx_q;
    pair_ab = SUM_W'(a) + SUM_W'(b);
    pair_cd = SUM_W'(c) + SUM_W'(d);
    case (cfg_cur.mode)
      MODE_PAIR:           vsum = SUM_W'(b) + SUM_W'(c);
      MODE_QUAD, MODE_QBIN: vsum = pair_ab + pair_cd;
      MODE_SBIN:           vsum = pair_ab;
      default:             vsum = SUM_W'(b);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      idx_q     <= '0;
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_eol   <= 1'b0;
      out_sum   <= '0;
      out_cfg   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cfg_q   <= cfg_cur;
        idx_q   <= idx_cur + 1'b1;
        out_sol <= in_sol;
        out_eol <= (idx_cur == IDX_W'(LINE_W - 1));
        out_sum <= vsum;
        out_cfg <= cfg_cur;
      end
    end
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_sol) |=> $stable(cfg_q));

endmodule

// File: rtl/lsb_hbin.sv
module lsb_hbin
  import lsb_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sol,
  input  logic             in_eol,
  input  logic [PIX_W+2:0] in_sum,
  input  line_cfg_t        in_cfg,
  output logic             out_valid,
  output logic             out_sol,
  output logic             out_eol,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_rev
);

  localparam int SUM_W = PIX_W + 3;
  localparam int MAXV  = (1 << PIX_W) - 1;

  logic             phase_q, phase_cur;
  logic [SUM_W-1:0] hold_q;
  logic             hold_sol_q;
  logic             binned, single, half_on, emit, emit_sol;
  logic [SUM_W-1:0] pre, scaled;
  logic [PIX_W-1:0] clipped;

  always_comb begin
    binned    = mode_binned(in_cfg.mode);
    single    = mode_single(in_cfg.mode);
    half_on   = in_cfg.half && !single;
    phase_cur = in_sol ? 1'b0 : phase_q;
    pre       = binned ? (hold_q + in_sum) : in_sum;
    scaled    = half_on ? (pre >> 1) : pre;
    clipped   = (scaled > SUM_W'(MAXV)) ? PIX_W'(MAXV) : scaled[PIX_W-1:0];
    emit      = in_valid && (!binned || phase_cur);
    emit_sol  = binned ? hold_sol_q : in_sol;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= 1'b0;
      hold_q     <= '0;
      hold_sol_q <= 1'b0;
      out_valid  <= 1'b0;
      out_sol    <= 1'b0;
      out_eol    <= 1'b0;
      out_pix    <= '0;
      out_rev    <= 1'b0;
    end else begin
      out_valid <= emit;
      if (in_valid) begin
        if (binned) begin
          phase_q <= ~phase_cur;
          if (!phase_cur) begin
            hold_q     <= in_sum;
            hold_sol_q <= in_sol;
          end
        end else begin
          phase_q <= 1'b0;
        end
      end
      if (emit) begin
        out_sol <= emit_sol;
        out_eol <= in_eol;
        out_pix <= clipped;
        out_rev <= in_cfg.rev;
      end
    end
  end

  // R1
  single_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && single) |=> (out_valid && (SUM_W'(out_pix) == $past(in_sum))));

  // R4
  bin_even_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && binned && !phase_cur) |=> !out_valid);

endmodule

// File: rtl/lsb_mirror.sv
module lsb_mirror #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sol,
  input  logic             in_eol,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_rev,
  output logic             out_valid,
  output logic             out_sol,
  output logic [PIX_W-1:0] out_pix
);

  localparam int AW    = $clog2(LINE_W);
  localparam int DEPTH = 2 * LINE_W;

  logic [PIX_W-1:0] mem [0:DEPTH-1];
  logic [PIX_W-1:0] rd_q;
  logic             wbank_q, rbank_q, rrev_q, ractive_q;
  logic [AW-1:0]    waddr_q, waddr_cur, rlast_q, rcnt_q, raddr;
  logic             start;

  always_comb begin
    waddr_cur = in_sol ? '0 : waddr_q;
    raddr     = rrev_q ? (rlast_q - rcnt_q) : rcnt_q;
    start     = in_valid && in_eol;
  end

  always_ff @(posedge clk) begin
    if (in_valid) mem[{wbank_q, waddr_cur}] <= in_pix;
  end

  always_ff @(posedge clk) begin
    if (ractive_q) rd_q <= mem[{rbank_q, raddr}];
  end

  assign out_pix = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbank_q   <= 1'b0;
      rbank_q   <= 1'b0;
      rrev_q    <= 1'b0;
      ractive_q <= 1'b0;
      waddr_q   <= '0;
      rlast_q   <= '0;
      rcnt_q    <= '0;
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
    end else begin
      out_valid <= ractive_q;
      out_sol   <= ractive_q && (rcnt_q == '0);
      if (in_valid) waddr_q <= waddr_cur + 1'b1;
      if (start) begin
        ractive_q <= 1'b1;
        rcnt_q    <= '0;
        rlast_q   <= waddr_cur;
        rrev_q    <= in_rev;
        rbank_q   <= wbank_q;
        wbank_q   <= ~wbank_q;
      end else if (ractive_q) begin
        if (rcnt_q == rlast_q) ractive_q <= 1'b0;
        else rcnt_q <= rcnt_q + 1'b1;
      end
    end
  end

  // R9
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eol) |-> (!ractive_q || (rcnt_q == rlast_q)));

  // R9
  burst_contig_chk: assert property (@(posedge clk) disable iff (rst)
    (ractive_q && (rcnt_q != rlast_q)) |=> (ractive_q && out_valid));

  // R9
  sol_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
    out_sol |-> out_valid);

endmodule

// File: rtl/linesum_bin.sv
module linesum_bin
  import lsb_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sol,
  input  logic [PIX_W-1:0] line_a,
  input  logic [PIX_W-1:0] line_b,
  input  logic [PIX_W-1:0] line_c,
  input  logic [PIX_W-1:0] line_d,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_half,
  input  logic             cfg_rev,
  output logic             out_valid,
  output logic             out_sol,
  output logic [PIX_W-1:0] out_pix
);

  localparam int SUM_W = PIX_W + 3;

  line_cfg_t        cfg_in, s1_cfg;
  logic             s1_valid, s1_sol, s1_eol;
  logic [SUM_W-1:0] s1_sum;
  logic             s2_valid, s2_sol, s2_eol, s2_rev;
  logic [PIX_W-1:0] s2_pix;

  assign cfg_in = '{mode: cfg_mode, half: cfg_half, rev: cfg_rev};

  lsb_vsum #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_vsum (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol),
    .a(line_a), .b(line_b), .c(line_c), .d(line_d), .cfg_in(cfg_in),
    .out_valid(s1_valid), .out_sol(s1_sol), .out_eol(s1_eol),
    .out_sum(s1_sum), .out_cfg(s1_cfg)
  );

  lsb_hbin #(.PIX_W(PIX_W)) u_hbin (
    .clk(clk), .rst(rst), .in_valid(s1_valid), .in_sol(s1_sol),
    .in_eol(s1_eol), .in_sum(s1_sum), .in_cfg(s1_cfg),
    .out_valid(s2_valid), .out_sol(s2_sol), .out_eol(s2_eol),
    .out_pix(s2_pix), .out_rev(s2_rev)
  );

  lsb_mirror #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_mirror (
    .clk(clk), .rst(rst), .in_valid(s2_valid), .in_sol(s2_sol),
    .in_eol(s2_eol), .in_pix(s2_pix), .in_rev(s2_rev),
    .out_valid(out_valid), .out_sol(out_sol), .out_pix(out_pix)
  );

endmodule

// File: tb/linesum_bin_test.sv
module linesum_bin_test;

  localparam int PW   = 8;
  localparam int LW   = 8;
  localparam int MAXV = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sol = 1'b0;
  logic [PW-1:0] la = '0, lb = '0, lc = '0, ld = '0;
  logic [2:0] cfg_mode = '0;
  logic cfg_half = 1'b0, cfg_rev = 1'b0;
  logic out_valid, out_sol;
  logic [PW-1:0] out_pix;

  always #5 clk = ~clk;

  linesum_bin #(.PIX_W(PW), .LINE_W(LW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol),
    .line_a(la), .line_b(lb), .line_c(lc), .line_d(ld),
    .cfg_mode(cfg_mode), .cfg_half(cfg_half), .cfg_rev(cfg_rev),
    .out_valid(out_valid), .out_sol(out_sol), .out_pix(out_pix)
  );

  int checks = 0;
  int errors = 0;
  int    exp_pix[$];
  bit    exp_sol[$];
  string exp_tag[$];
  bit    prev_v = 1'b0;

  function automatic int pixval(int seed, int i, int lane, int mask);
    if (mask < 0) return MAXV;
    return (seed * 37 + i * 53 + lane * 91 + seed * i * 7 + lane * i * 13) & mask;
  endfunction

  function automatic int vsum_e(int mode, int a, int b, int c, int d);
    case (mode)
      1: return b + c;
      2, 4: return (a + b) + (c + d);
      3: return a + b;
      default: return b;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        checks++;
        if (exp_pix.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected pixel got %0d expected none", out_pix);
        end else begin
          int e; bit s; string t;
          e = exp_pix.pop_front();
          s = exp_sol.pop_front();
          t = exp_tag.pop_front();
          if (out_pix !== e[PW-1:0] || out_sol !== s) begin
            errors++;
            $display("FAIL %s pix/sol got %0d/%0d expected %0d/%0d", t, out_pix, out_sol, e, s);
          end
          if (!prev_v && !s) begin
            errors++;
            $display("FAIL R9 burst gap before pixel got valid-rise mid-line expected contiguous");
          end
        end
      end
      prev_v = out_valid;
    end
  end

  task automatic send_line(int mode, int half, int rev, int seed, int mask,
                           bit scramble, bit midgap, int gap);
    int v[LW];
    int o[LW];
    bit so[LW];
    int n;
    bit binned, single;
    string tag;
    binned = (mode == 3) || (mode == 4);
    single = !((mode >= 1) && (mode <= 4));
    for (int i = 0; i < LW; i++)
      v[i] = vsum_e(mode, pixval(seed, i, 0, mask), pixval(seed, i, 1, mask),
                    pixval(seed, i, 2, mask), pixval(seed, i, 3, mask));
    n = binned ? LW / 2 : LW;
    for (int k = 0; k < n; k++) begin
      int s;
      s = binned ? (v[2*k] + v[2*k+1]) : v[k];
      if (half != 0 && !single) s = s >> 1;
      so[k] = (s > MAXV);
      o[k] = so[k] ? MAXV : s;
    end
    case (mode)
      1: tag = "R2";
      2: tag = "R3";
      3: tag = "R4";
      4: tag = "R5";
      default: tag = "R1";
    endcase
    if (half != 0) tag = {tag, "/R6"};
    if (rev != 0) tag = {tag, "/R8"};
    if (scramble) tag = {tag, "/R10"};
    for (int k = 0; k < n; k++) begin
      int j;
      j = (rev != 0) ? (n - 1 - k) : k;
      exp_pix.push_back(o[j]);
      exp_sol.push_back(k == 0);
      exp_tag.push_back(so[j] ? {tag, "/R7"} : tag);
    end
    for (int i = 0; i < LW; i++) begin
      @(negedge clk);
      if (midgap && i == 3) begin
        in_valid = 1'b0;
        in_sol = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_sol = (i == 0);
      la = PW'(pixval(seed, i, 0, mask));
      lb = PW'(pixval(seed, i, 1, mask));
      lc = PW'(pixval(seed, i, 2, mask));
      ld = PW'(pixval(seed, i, 3, mask));
      if (i == 0) begin
        cfg_mode = 3'(mode);
        cfg_half = (half != 0);
        cfg_rev  = (rev != 0);
      end else if (scramble) begin
        cfg_mode = 3'(mode) ^ 3'b110;
        cfg_half = (half == 0);
        cfg_rev  = (rev == 0);
      end
    end
    if (gap > 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sol = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 during reset
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 out_valid in reset got %0b expected 0", out_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    // R11 just after reset
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 out_valid after reset got %0b expected 0", out_valid);
    end
    for (int m = 0; m < 6; m++)
      for (int h = 0; h < 2; h++)
        for (int r = 0; r < 2; r++) begin
          int sd;
          sd = m * 4 + h * 2 + r + 1;
          send_line(m, h, r, sd, (sd % 3 == 0) ? 31 : 255,
                    (sd % 2) == 1, (sd % 5) == 0, (sd % 4 == 0) ? 3 : 0);
        end
    // R7: full-scale inputs in quad binned and pair modes
    send_line(4, 0, 0, 7, -1, 1'b0, 1'b0, 0);
    send_line(1, 1, 1, 7, -1, 1'b0, 1'b0, 0);
    // R3/R5 back to back with mirror toggling
    send_line(2, 1, 1, 41, 255, 1'b1, 1'b0, 0);
    send_line(4, 1, 0, 42, 255, 1'b0, 1'b0, 0);
    send_line(0, 1, 1, 43, 255, 1'b1, 1'b0, 5);
    repeat (40) @(negedge clk);
    // R9 every line emitted
    checks++;
    if (exp_pix.size() != 0) begin
      errors++;
      $display("FAIL R9 pending pixels got %0d expected 0", exp_pix.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule